// File: doc/BRIEF.md
# Mutually Clocked Two-Register Keystream Generator

This block produces a keystream one bit per clock from two 128-bit shift registers. One register is linear. On each step it either advances as a Galois LFSR or multiplies its state by (x+1), and the mode is chosen fresh every clock. The other register is nonlinear and picks one of two feedback masks on each step. Each register's choice is driven by a control bit taken from both registers, so the two registers govern each other's stepping. Each keystream bit is the XOR of the lowest bits of the two registers.

To start, the user pulses `start` with a key, an IV of 0 to 128 bits and the IV length. The block then clears both registers. It shifts in the IV bits and then the key bits, one per clock, and runs a fixed number of mixing clocks before any output is allowed. During that setup period the output flop stays closed. Once setup ends, every clock with `ks_en` high produces one keystream bit, marked by `ks_valid` on the next cycle.

Top module: `dual_reg_keygen`

## Requirements
- R1: While `rst_n` is low, `ks_valid` and `ks_bit` are 0 at the next clock edge.
- R2: The linear register's mode bit is S[43] XOR R[85]. The nonlinear register's mode bit is S[85] XOR R[42]. Both are taken from the state before the step.
- R3: A linear step with feedback f = R[127] XOR input is R_next = (R << 1) XOR (TAPS AND f). When the mode bit is 1, the current R is also XORed in, which multiplies the state by (x+1).
- R4: A nonlinear step with f = S[127] XOR input works as follows. Stage i, for 0 < i < 127, takes S[i-1] XOR ((S[i] XOR C0[i]) AND (S[i+1] XOR C1[i])). Stage 127 takes S[126], and stage 0 takes 0. The result is then XORed with f AND (mode ? FB1 : FB0).
- R5: A `start` pulse clears both registers. It then steps them with input bits iv[0] up to iv[len-1], then key[0] to key[127], then 128 zeros, at one bit per clock.
- R6: An `iv_len` of 0 skips the IV bits. Values above 128 are treated as 128.
- R7: From `start` to the end of the mixing clocks, `ks_valid` stays 0 and `ks_bit` stays 0, whatever `ks_en` does.
- R8: After setup, each clock with `ks_en` high steps both registers with input 0. On the next cycle `ks_valid` is 1 and `ks_bit` equals R[0] XOR S[0] from before the step. With `ks_en` low there is no step, `ks_valid` is 0 and `ks_bit` holds its value.
- R9: A `start` in any phase, including during output, restarts setup from cleared registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new setup with the present key, IV and length |
| key | input | 128 | Secret key, bit 0 loaded first |
| iv | input | 128 | Initial value, bit 0 loaded first |
| iv_len | input | 8 | Number of IV bits to load (0 to 128, larger clamps) |
| ks_en | input | 1 | Request one keystream bit this clock |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | `ks_bit` holds a fresh bit |

## Verification
The generator is run with IV lengths of 37, 0, 128 and 200. The 0 case shows that the IV phase is skipped. The 200 case must reproduce the 128 result, which separates clamping from wrapping. Keystream is drawn continuously and with `ks_en` gaps, which distinguishes a missed step from a stalled output. `ks_en` also toggles during setup to show that it has no effect there. Restarts in mid-setup and mid-output must reproduce an earlier stream exactly. The linear register is also driven alone, with a fixed vector in each mode, so that the (x+1) step is observed on its own.

// File: rtl/keygen_pkg.sv
// Shared types and default constants for the two-register keystream generator.
// Assumes a 128-bit register width for the default masks.
package keygen_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_IV,
        PH_KEY,
        PH_MIX,
        PH_RUN
    } phase_t;

    parameter logic [127:0] DEF_TAPS = 128'hA3C5_5E19_0D72_B84F_6E21_93DA_47C0_1B5D;
    parameter logic [127:0] DEF_C0   = 128'h5D1A_E873_2C94_F60B_17BE_8A35_C26F_0349;
    parameter logic [127:0] DEF_C1   = 128'h9F40_3B6D_C815_72E2_A0D9_4E87_1F3C_65B8;
    parameter logic [127:0] DEF_FB0  = 128'hE6B2_1C58_7A0F_D943_2E8B_C571_06DA_3F95;
    parameter logic [127:0] DEF_FB1  = 128'h4C87_F21D_0B6E_93A5_78D4_1FE0_62B9_C72B;

endpackage

// File: rtl/keygen_lin.sv
// Linear register with a per-clock mode: a Galois LFSR shift, or the same shift
// with the old state XORed back in (multiplication by x+1).
// Assumes clr has priority over step; input bit is folded into the feedback.
module keygen_lin #(
    parameter int          W    = 128,
    parameter logic [W-1:0] TAPS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         in_bit,
    input  logic         mode,
    output logic [W-1:0] state
);

    logic         fb;
    logic [W-1:0] nxt;

    // next-state: shift, tap feedback, and optional self-XOR per stage
    always_comb begin
        fb  = state[W-1] ^ in_bit;
        nxt = {state[W-2:0], 1'b0} ^ (TAPS & {W{fb}}) ^ (state & {W{mode}});
    end

    // state register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= '0;
        end else if (step) begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/keygen_nl.sv
// Nonlinear register: shift with per-stage AND mixing against two constant
// masks, then feedback through one of two masks chosen by the mode bit.
// Assumes W >= 3 so inner stages exist.
module keygen_nl #(
    parameter int           W   = 128,
    parameter logic [W-1:0] C0  = '0,
    parameter logic [W-1:0] C1  = '0,
    parameter logic [W-1:0] FB0 = '1,
    parameter logic [W-1:0] FB1 = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         in_bit,
    input  logic         mode,
    output logic [W-1:0] state
);

    logic         fb;
    logic [W-1:0] sh;
    logic [W-1:0] nxt;

    // per-stage shifted and mixed value
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_lo
            assign sh[i] = 1'b0;
        end else if (i == W-1) begin : g_hi
            assign sh[i] = state[i-1];
        end else begin : g_mid
            assign sh[i] = state[i-1] ^
                           ((state[i] ^ C0[i]) & (state[i+1] ^ C1[i]));
        end
    end

    // feedback through the mask picked by the mode bit
    always_comb begin
        fb  = state[W-1] ^ in_bit;
        nxt = sh ^ ({W{fb}} & (mode ? FB1 : FB0));
    end

    // state register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= '0;
        end else if (step) begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/keygen_seq.sv
// Setup sequencer: latches key, IV and clamped length on start, then feeds
// IV bits, key bits and zero mixing bits one per clock before entering run.
// Assumes start restarts from any phase.
module keygen_seq
    import keygen_pkg::*;
#(
    parameter int W     = 128,
    parameter int LEN_W = $clog2(W+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     key,
    input  logic [W-1:0]     iv,
    input  logic [LEN_W-1:0] iv_len,
    output logic             setup_step,
    output logic             in_bit,
    output logic             run,
    output logic             busy
);

    localparam int               IDX_W = $clog2(W);
    localparam logic [LEN_W-1:0] WMAX  = LEN_W'(W);
    localparam logic [LEN_W-1:0] LAST  = LEN_W'(W-1);

    phase_t           phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;
    logic [W-1:0]     key_q;
    logic [W-1:0]     iv_q;

    // clamp the requested IV length to the register width
    always_comb begin
        len_eff = (iv_len > WMAX) ? WMAX : iv_len;
    end

    // phase and bit counter progression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            len_q <= '0;
            key_q <= '0;
            iv_q  <= '0;
        end else if (start) begin
            phase <= (len_eff == '0) ? PH_KEY : PH_IV;
            cnt   <= '0;
            len_q <= len_eff;
            key_q <= key;
            iv_q  <= iv;
        end else begin
            case (phase)
                PH_IV: begin
                    if (cnt == len_q - 1'b1) begin
                        phase <= PH_KEY;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_KEY: begin
                    if (cnt == LAST) begin
                        phase <= PH_MIX;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_MIX: begin
                    if (cnt == LAST) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // bit fed into both feedbacks and step request for setup phases
    always_comb begin
        case (phase)
            PH_IV:   in_bit = iv_q[cnt[IDX_W-1:0]];
            PH_KEY:  in_bit = key_q[cnt[IDX_W-1:0]];
            default: in_bit = 1'b0;
        endcase
        setup_step = !start &&
                     (phase == PH_IV || phase == PH_KEY || phase == PH_MIX);
        run  = (phase == PH_RUN);
        busy = (phase != PH_RUN);
    end

endmodule

// File: rtl/dual_reg_keygen.sv
// Top: two mutually clocked registers with a gated keystream output flop.
// Mode bits are formed from both registers before each step; the output
// flop only latches during the run phase on ks_en.
module dual_reg_keygen
    import keygen_pkg::*;
#(
    parameter int           W      = 128,
    parameter logic [W-1:0] TAPS   = DEF_TAPS,
    parameter logic [W-1:0] C0     = DEF_C0,
    parameter logic [W-1:0] C1     = DEF_C1,
    parameter logic [W-1:0] FB0    = DEF_FB0,
    parameter logic [W-1:0] FB1    = DEF_FB1,
    parameter int           LM_S   = 43,
    parameter int           LM_R   = 85,
    parameter int           NM_S   = 85,
    parameter int           NM_R   = 42,
    parameter int           LEN_W  = $clog2(W+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     key,
    input  logic [W-1:0]     iv,
    input  logic [LEN_W-1:0] iv_len,
    input  logic             ks_en,
    output logic             ks_bit,
    output logic             ks_valid
);

    logic         setup_step;
    logic         seq_bit;
    logic         run;
    logic         busy;
    logic         out_step;
    logic         step;
    logic         lin_mode;
    logic         nl_mode;
    logic [W-1:0] r_st;
    logic [W-1:0] s_st;

    keygen_seq #(.W(W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .key        (key),
        .iv         (iv),
        .iv_len     (iv_len),
        .setup_step (setup_step),
        .in_bit     (seq_bit),
        .run        (run),
        .busy       (busy)
    );

    // cross-coupled mode bits and the combined step enable
    always_comb begin
        lin_mode = s_st[LM_S] ^ r_st[LM_R];
        nl_mode  = s_st[NM_S] ^ r_st[NM_R];
        out_step = run && ks_en && !start;
        step     = setup_step || out_step;
    end

    keygen_lin #(.W(W), .TAPS(TAPS)) u_lin (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .step   (step),
        .in_bit (seq_bit),
        .mode   (lin_mode),
        .state  (r_st)
    );

    keygen_nl #(.W(W), .C0(C0), .C1(C1), .FB0(FB0), .FB1(FB1)) u_nl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .step   (step),
        .in_bit (seq_bit),
        .mode   (nl_mode),
        .state  (s_st)
    );

    // output flop: closed during setup, latches pre-step bit on request
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            ks_bit   <= 1'b0;
            ks_valid <= 1'b0;
        end else if (out_step) begin
            ks_bit   <= r_st[0] ^ s_st[0];
            ks_valid <= 1'b1;
        end else begin
            ks_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_reg_keygen_chk.sv
// Protocol checker for the keystream generator, bound to the top module.
// Assumes it sees the internal busy flag (setup or idle, not run phase).
module dual_reg_keygen_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ks_en,
    input logic ks_bit,
    input logic ks_valid,
    input logic busy
);

    AST_QUIET_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ks_valid); // R7

    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> ($past(ks_en) && !$past(busy))); // R8

    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ks_valid && !$past(start)) |-> $stable(ks_bit)); // R8

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !ks_valid)); // R9

    AST_START_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ks_bit); // R7

endmodule

bind dual_reg_keygen dual_reg_keygen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ks_en    (ks_en),
    .ks_bit   (ks_bit),
    .ks_valid (ks_valid),
    .busy     (busy)
);

// File: tb/tb_dual_reg_keygen.sv
// Bench: behavioural queue-driven model compared every clock, plus directed
// checks on the linear register alone and on clamp/restart reproducibility.
module tb_dual_reg_keygen;
    import keygen_pkg::*;

    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] key = '0;
    logic [W-1:0] iv = '0;
    logic [7:0]   iv_len = '0;
    logic         ks_en = 1'b0;
    logic         ks_bit;
    logic         ks_valid;

    logic         l_clr = 1'b0;
    logic         l_step = 1'b0;
    logic         l_in = 1'b0;
    logic         l_mode = 1'b0;
    logic [W-1:0] l_state;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dual_reg_keygen #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
        .iv_len(iv_len), .ks_en(ks_en), .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    keygen_lin #(.W(W), .TAPS(DEF_TAPS)) u_lin (
        .clk(clk), .rst_n(rst_n), .clr(l_clr), .step(l_step),
        .in_bit(l_in), .mode(l_mode), .state(l_state)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [W-1:0] mr, ms;
    bit         q[$];
    bit         armed, ev, eb;

    task automatic model_step(input bit b);
        bit cr, cs, fr, fs, lo, mix;
        bit [W-1:0] nr, ns;
        cr = ms[43] ^ mr[85];
        cs = ms[85] ^ mr[42];
        fr = mr[W-1] ^ b;
        fs = ms[W-1] ^ b;
        for (int i = 0; i < W; i++) begin
            lo    = (i == 0) ? 1'b0 : mr[i-1];
            nr[i] = lo ^ (fr & DEF_TAPS[i]) ^ (cr & mr[i]);
            lo    = (i == 0) ? 1'b0 : ms[i-1];
            mix   = (i > 0 && i < W-1) ?
                    ((ms[i] ^ DEF_C0[i]) & (ms[(i+1)%W] ^ DEF_C1[i])) : 1'b0;
            ns[i] = lo ^ mix ^ (fs & (cs ? DEF_FB1[i] : DEF_FB0[i]));
        end
        mr = nr;
        ms = ns;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mr = '0; ms = '0; q.delete(); armed = 0; ev = 0; eb = 0;
        end else if (start) begin
            int len;
            len = (iv_len > 8'd128) ? 128 : int'(iv_len);
            mr = '0; ms = '0; q.delete();
            for (int i = 0; i < len; i++) q.push_back(iv[i]);
            for (int i = 0; i < W; i++) q.push_back(key[i]);
            for (int i = 0; i < W; i++) q.push_back(1'b0);
            armed = 1; ev = 0; eb = 0;
        end else if (q.size() != 0) begin
            model_step(q.pop_front());
            ev = 0;
        end else if (armed && ks_en) begin
            eb = mr[0] ^ ms[0];
            ev = 1;
            model_step(1'b0);
        end else begin
            ev = 0;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(ks_valid === 1'b0, "R1 valid in reset", W'(ks_valid), '0);
            chk(ks_bit === 1'b0, "R1 bit in reset", W'(ks_bit), '0);
        end else if (q.size() != 0 || !armed) begin
            chk(ks_valid === ev, "R7 valid in setup", W'(ks_valid), W'(ev));
            chk(ks_bit === eb, "R7 bit in setup", W'(ks_bit), W'(eb));
        end else begin
            chk(ks_valid === ev, "R8 valid in run", W'(ks_valid), W'(ev));
            chk(ks_bit === eb, "R8 R2 R3 R4 R5 keystream bit", W'(ks_bit), W'(eb));
        end
    end

    // one full setup plus n output cycles; captures the first 64 bits
    task automatic run_one(input logic [W-1:0] k, input logic [W-1:0] v,
                           input logic [7:0] len, input int n, input int gap,
                           output logic [63:0] cap);
        int eff, idx;
        eff = (len > 8'd128) ? 128 : int'(len);
        idx = 0;
        cap = '0;
        @(negedge clk);
        key = k; iv = v; iv_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < eff + 2*W; c++) begin
            ks_en = c[0];
            @(negedge clk);
        end
        for (int c = 0; c < n; c++) begin
            ks_en = (gap == 0) ? 1'b1 : (c % gap != 0);
            @(negedge clk);
            if (ks_valid && idx < 64) begin
                cap[idx] = ks_bit;
                idx++;
            end
        end
        ks_en = 1'b0;
    endtask

    logic [63:0] cap_a, cap_b, cap_c, cap_d, cap_e;

    initial begin
        logic [W-1:0] v1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R3: linear register alone, plain step then x+1 step then plain
        @(negedge clk); l_clr = 1'b1;
        @(negedge clk); l_clr = 1'b0; l_step = 1'b1; l_in = 1'b1; l_mode = 1'b0;
        @(negedge clk); l_in = 1'b0;
        chk(l_state === DEF_TAPS, "R3 plain step from zero", l_state, DEF_TAPS);
        l_mode = 1'b1;
        v1 = {DEF_TAPS[W-2:0], 1'b0} ^ (DEF_TAPS[W-1] ? DEF_TAPS : '0) ^ DEF_TAPS;
        @(negedge clk);
        chk(l_state === v1, "R3 x+1 step", l_state, v1);
        l_mode = 1'b0;
        @(negedge clk);
        v1 = {v1[W-2:0], 1'b0} ^ (v1[W-1] ? DEF_TAPS : '0);
        chk(l_state === v1, "R3 plain step", l_state, v1);
        l_step = 1'b0;
        @(negedge clk);
        chk(l_state === v1, "R3 hold without step", l_state, v1);

        run_one(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
                128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 8'd37, 300, 0, cap_a);
        run_one(128'hDEAD_BEEF_0BAD_F00D_1357_9BDF_2468_ACE0,
                128'h1111_2222_3333_4444_5555_6666_7777_8888, 8'd0, 200, 3, cap_b);
        run_one(128'h5A5A_A5A5_C3C3_3C3C_9696_6969_F00F_0FF0,
                128'h8421_4218_2184_1842_7BDE_BDE7_DE7B_E7BD, 8'd128, 150, 0, cap_c);
        run_one(128'h5A5A_A5A5_C3C3_3C3C_9696_6969_F00F_0FF0,
                128'h8421_4218_2184_1842_7BDE_BDE7_DE7B_E7BD, 8'd200, 150, 4, cap_d);
        chk(cap_c === cap_d, "R6 length above 128 clamps", W'(cap_d), W'(cap_c));

        // R9: restart during setup, then reproduce the first stream
        @(negedge clk);
        key = '1; iv = '0; iv_len = 8'd90; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        run_one(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
                128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 8'd37, 100, 0, cap_e);
        chk(cap_e === cap_a, "R9 restart reproduces stream", W'(cap_e), W'(cap_a));
        chk(cap_a !== cap_b, "R5 key and IV change stream", W'(cap_a), W'(cap_b));

        // R9: restart from the run phase with the same inputs as run b
        run_one(128'hDEAD_BEEF_0BAD_F00D_1357_9BDF_2468_ACE0,
                128'h1111_2222_3333_4444_5555_6666_7777_8888, 8'd0, 200, 3, cap_e);
        chk(cap_e === cap_b, "R9 restart from run", W'(cap_e), W'(cap_b));

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule